// File: doc/BRIEF.md
# Parallel Lane LFSR Pattern Generator

This block produces a 20-bit pseudo-random test word on every transfer. It is meant to feed the parallel transmit side of a serial transceiver during link testing. The word is not drawn from one wide polynomial. Twenty small 5-bit shift registers run side by side, one for each bit lane, and each lane gives the word its top bit. All lanes share the same period of 31, so the word sequence repeats every 31 transfers. It starts from a fixed seed word, which lets a checker on the far side rebuild the same sequence.

A plain run/stop input turns the source on and off. The word leaves on a valid/ready stream. `out_valid` follows the run input. A word moves on only when `out_valid` and `out_ready` are both high at a rising clock edge. While the sink holds `out_ready` low, the word, the first-word marker and all lane states stay as they are. `out_first` marks the word that opens each 31-word period. A synchronous reset puts every lane back to its seed state.

Top module: `lane_lfsr_pattern_gen`

## Requirements
- R1: After reset, the first word offered with run high is 20'h695A7, with `out_first` high.
- R2: Each lane is a 5-bit register with state s. Bit i of `out_data` is s[4] of lane i. On a transfer, s becomes {s[3:0], s[4]^s[2]}, which is the polynomial x^5+x^3+1. Lane i resets to {seed bit i, 4'b0001}.
- R3: Over 31 transfers in a row, each lane bit is 1 in exactly 16 words. Word 32 equals word 1.
- R4: While run is low, `out_valid` is 0, `out_data` is 0 and `out_first` is 0. The lane states hold, so when run returns, the sequence goes on with the word that had not yet been transferred.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` and `out_first` stay stable, and no lane advances.
- R6: `out_first` is high exactly when a valid word is the first word of a period, and such a word always equals the seed 20'h695A7.
- R7: A reset given partway through a period brings the next offered word back to the seed, with `out_first` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Start/stop control; high offers words |
| out_ready | input | 1 | Sink accepts the current word |
| out_data | output | 20 | Pattern word, zero while stopped |
| out_valid | output | 1 | Word on out_data is offered |
| out_first | output | 1 | Offered word opens a 31-word period |

## Verification
The pattern is checked in four ways. The first is an uninterrupted run with ready held high for 32 transfers. This checks every word against a lane model and shows the period and the per-lane balance of ones. The second stops the run partway through, which separates holding the lane state from restarting at the seed. The third drops ready for a few cycles to show that back-pressure freezes the word without skipping one. The fourth applies a reset partway through a period, which tells a true return to the seed apart from a sequence that only goes on.

// File: rtl/lfsr_pat_pkg.sv
package lfsr_pat_pkg;
  localparam int unsigned DEF_LANES  = 20;
  localparam int unsigned DEF_LFSR_W = 5;
  localparam int unsigned DEF_TAP_LO = 2;
  localparam logic [DEF_LANES-1:0] DEF_SEED = 20'h695A7;

  typedef enum logic [1:0] {
    GEN_IDLE    = 2'b00,
    GEN_STALL   = 2'b01,
    GEN_ADVANCE = 2'b11
  } gen_mode_e;
endpackage

// File: rtl/lfsr_pat_lane.sv
module lfsr_pat_lane #(
  parameter int unsigned W      = 5,
  parameter int unsigned TAP_LO = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic seed_bit,
  output logic msb
);
  localparam logic [W-2:0] LOW_INIT = {{(W-2){1'b0}}, 1'b1};

  logic [W-1:0] state_q;
  logic         fb;

  assign fb  = state_q[W-1] ^ state_q[TAP_LO];
  assign msb = state_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= {seed_bit, LOW_INIT};
    end else if (adv) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end
endmodule

// File: rtl/lfsr_pat_phase.sv
module lfsr_pat_phase #(
  parameter int unsigned PERIOD = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic at_start
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign at_start = (cnt_q == '0);
endmodule

// File: rtl/lfsr_pat_out.sv
module lfsr_pat_out
  import lfsr_pat_pkg::*;
#(
  parameter int unsigned LANES = 20
) (
  input  logic             run,
  input  logic             ready,
  input  logic [LANES-1:0] raw_word,
  input  logic             at_start,
  output logic [LANES-1:0] data,
  output logic             valid,
  output logic             first,
  output logic             adv
);
  gen_mode_e mode;

  always_comb begin
    if (!run)       mode = GEN_IDLE;
    else if (ready) mode = GEN_ADVANCE;
    else            mode = GEN_STALL;
  end

  assign valid = (mode != GEN_IDLE);
  assign adv   = (mode == GEN_ADVANCE);
  assign data  = valid ? raw_word : '0;
  assign first = valid & at_start;
endmodule

// File: rtl/lane_lfsr_pattern_gen.sv
module lane_lfsr_pattern_gen
  import lfsr_pat_pkg::*;
#(
  parameter int unsigned     LANES  = DEF_LANES,
  parameter int unsigned     LFSR_W = DEF_LFSR_W,
  parameter int unsigned     TAP_LO = DEF_TAP_LO,
  parameter logic [LANES-1:0] SEED  = DEF_SEED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             out_ready,
  output logic [LANES-1:0] out_data,
  output logic             out_valid,
  output logic             out_first
);
  localparam int unsigned PERIOD = (1 << LFSR_W) - 1;

  logic [LANES-1:0] raw_word;
  logic             adv;
  logic             at_start;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lfsr_pat_lane #(
      .W      (LFSR_W),
      .TAP_LO (TAP_LO)
    ) lane_i (
      .clk      (clk),
      .rst      (rst),
      .adv      (adv),
      .seed_bit (SEED[g]),
      .msb      (raw_word[g])
    );
  end

  lfsr_pat_phase #(
    .PERIOD (PERIOD)
  ) phase_i (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .at_start (at_start)
  );

  lfsr_pat_out #(
    .LANES (LANES)
  ) out_i (
    .run      (run),
    .ready    (out_ready),
    .raw_word (raw_word),
    .at_start (at_start),
    .data     (out_data),
    .valid    (out_valid),
    .first    (out_first),
    .adv      (adv)
  );
endmodule

// File: rtl/lane_lfsr_pattern_gen_chk.sv
module lane_lfsr_pattern_gen_chk #(
  parameter int unsigned     LANES = 20,
  parameter logic [LANES-1:0] SEED = 20'h695A7
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             out_ready,
  input logic [LANES-1:0] out_data,
  input logic             out_valid,
  input logic             out_first
);
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |-> (out_data == '0 && !out_valid && !out_first));

  a_r5_stall_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (!run || ($stable(out_data) && $stable(out_first))));

  a_r6_first_is_seed: assert property (@(posedge clk) disable iff (rst)
    out_first |-> (out_valid && out_data == SEED));

  a_r1_seed_after_reset: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && run) |-> (out_data == SEED && out_first));

  a_r3_no_double_first: assert property (@(posedge clk) disable iff (rst)
    (out_first && out_ready) |=> !out_first);
endmodule

bind lane_lfsr_pattern_gen lane_lfsr_pattern_gen_chk #(
  .LANES (LANES),
  .SEED  (SEED)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_first (out_first)
);

// File: tb/lane_lfsr_pattern_gen_tb_top.sv
module lane_lfsr_pattern_gen_tb_top;
  localparam int unsigned LANES = 20;
  localparam logic [LANES-1:0] SEED = 20'h695A7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             run = 1'b0;
  logic             out_ready = 1'b0;
  logic [LANES-1:0] out_data;
  logic             out_valid;
  logic             out_first;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0]       mst [LANES];
  logic [LANES-1:0] mphase;
  int               mpos;

  always #10 clk = ~clk;

  lane_lfsr_pattern_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_first (out_first)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] model_word();
    logic [LANES-1:0] w;
    for (int i = 0; i < LANES; i++) w[i] = mst[i][4];
    return w;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < LANES; i++) mst[i] = {SEED[i], 4'b0001};
    mpos = 0;
  endtask

  task automatic model_step();
    for (int i = 0; i < LANES; i++) mst[i] = {mst[i][3:0], mst[i][4] ^ mst[i][2]};
    mpos = (mpos + 1) % 31;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; run = 1'b0; out_ready = 1'b0;
    cyc(); cyc();
    rst = 1'b0;
    model_reset();
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check("R4 idle valid", out_valid, 0);
    check("R4 idle data", out_data, 0);
    check("R4 idle first", out_first, 0);
    run = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R1 seed word", out_data, SEED);
    check("R1 first flag", out_first, 1);
    cyc();
  endtask

  task automatic t_full_period();
    logic [LANES-1:0] words [32];
    int ones;
    int bad;
    do_reset();
    run = 1'b1; out_ready = 1'b1;
    bad = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      words[k] = out_data;
      check("R2 lane word", out_data, model_word());
      check("R6 first flag", out_first, (mpos == 0));
      cyc();
      model_step();
    end
    check("R3 word32 equals word1", words[31], words[0]);
    for (int i = 0; i < LANES; i++) begin
      ones = 0;
      for (int k = 0; k < 31; k++) ones += words[k][i];
      if (ones != 16) bad++;
    end
    check("R3 lanes with 16 ones", bad, 0);
    run = 1'b0;
  endtask

  task automatic t_idle_hold();
    do_reset();
    run = 1'b1; out_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin cyc(); model_step(); end
    run = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4 stopped data", out_data, 0);
      check("R4 stopped valid", out_valid, 0);
      cyc();
    end
    run = 1'b1;
    @(negedge clk);
    check("R4 resume word", out_data, model_word());
    check("R4 resume first", out_first, 0);
    cyc(); model_step();
    @(negedge clk);
    check("R4 resume next", out_data, model_word());
    run = 1'b0;
  endtask

  task automatic t_backpressure();
    logic [LANES-1:0] held;
    do_reset();
    run = 1'b1; out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin cyc(); model_step(); end
    out_ready = 1'b0;
    @(negedge clk);
    held = out_data;
    check("R5 stall word", held, model_word());
    for (int k = 0; k < 4; k++) begin
      cyc();
      @(negedge clk);
      check("R5 stall stable", out_data, held);
    end
    out_ready = 1'b1;
    cyc(); model_step();
    @(negedge clk);
    check("R5 no skipped word", out_data, model_word());
    run = 1'b0;
  endtask

  task automatic t_reset_mid();
    do_reset();
    run = 1'b1; out_ready = 1'b1;
    for (int k = 0; k < 11; k++) cyc();
    @(negedge clk);
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    @(negedge clk);
    check("R7 seed after mid reset", out_data, SEED);
    check("R7 first after mid reset", out_first, 1);
    run = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_full_period();
    t_idle_hold();
    t_backpressure();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule